// File: doc/BRIEF.md
# Multi-Port Physical Register Freelist

This block keeps track of which physical registers can be given out by the rename stage. It has one allocation port for each slot of the rename window. Each port always presents the index of a register that is free now, together with a valid bit. The ports never present the same register in the same cycle. Port 0 offers the lowest-indexed free register, port 1 offers the next one, and so on. Rename logic asserts a port's alloc strobe only for slots that need a new destination register. The offered register is then in use from the next clock on.

A single release port returns a register to the pool, and that register is free from the next clock on. The rename stage decides when registers are released; this block does not. Physical register 0 holds the constant zero, so it is never free and is never offered.

Top module: `pfl_freelist`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to its initial state: every register except register 0 is free. After that, port k offers index k+1 with its valid bit high, for every port when NUM_PREGS > SLOTS.
- R2: Port k offers the (k+1)-th lowest-indexed free register. Port 0 offers the lowest one.
- R3: No two ports with valid high offer the same index in the same cycle.
- R4: When fewer free registers exist than there are ports, only the lowest-numbered ports have valid high. The valid bits always form a contiguous run starting at port 0. A port with valid low drives index 0.
- R5: An alloc strobe on a port whose valid bit is high removes the offered register from the pool from the next clock on.
- R6: In a cycle with no effective alloc and no effective release, the offers are unchanged at the next clock.
- R7: A release with `rel_valid_i` high and a nonzero `rel_idx_i` makes that register free from the next clock on. If the same register is also allocated in that cycle, the release takes precedence.
- R8: A release of index 0 has no effect.
- R9: An alloc strobe on a port whose valid bit is low has no effect.
- R10: A port with valid high never offers index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_i | input | SLOTS | Per-port claim strobe for the register offered this cycle |
| offer_valid_o | output | SLOTS | Per-port flag that the offered index is a free register |
| offer_idx_o | output | SLOTS x clog2(NUM_PREGS) | Per-port offered register index, 0 when invalid |
| rel_valid_i | input | 1 | Release strobe |
| rel_idx_i | input | clog2(NUM_PREGS) | Index of the register being returned |

## Verification
The offers are combinational outputs of the pool state, so they are checked in the same cycle that the inputs are applied. The effect of an alloc or a release shows up in the offers exactly one clock edge later. The driver task computes the offers expected for the current cycle from a model of the pool. It queues those offers before the falling edge and applies that cycle's alloc and release to the model only at the following rising edge. The monitor pops and compares at every falling edge, so each result is sampled half a cycle away from the edge that produced it.

// File: rtl/pfl_pkg.sv
// Package: shared defaults for the physical register freelist.
// Assumes: consumers override the defaults through module parameters.
package pfl_pkg;
    localparam int PFL_DEF_NPREG = 64;  // physical registers, index 0 reserved
    localparam int PFL_DEF_SLOTS = 4;   // rename window width
endpackage

// File: rtl/pfl_pick.sv
// Module: pfl_pick
// Finds the lowest set bit of a candidate mask. Returns its index, a valid
// flag and a one-hot vector of the chosen bit.
// Assumes: the mask may be all zero. Index 0 is then driven with valid low.
module pfl_pick #(
    parameter int NBITS = pfl_pkg::PFL_DEF_NPREG,
    localparam int IW = $clog2(NBITS)
) (
    input  logic [NBITS-1:0] cand_i,
    output logic [NBITS-1:0] pick_oh_o,
    output logic [IW-1:0]    pick_idx_o,
    output logic             pick_vld_o
);
    // isolate the lowest set bit with the two's-complement trick
    always_comb begin
        pick_oh_o = cand_i & (~cand_i + NBITS'(1));
    end

    // encode the one-hot choice into a binary index
    always_comb begin
        pick_idx_o = '0;
        pick_vld_o = 1'b0;
        for (int i = 0; i < NBITS; i++) begin
            if (pick_oh_o[i]) begin
                pick_idx_o = IW'(i);
                pick_vld_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pfl_state.sv
// Module: pfl_state
// Holds one free bit per physical register. Clears the bits named by the
// claim mask and sets the bits named by the return mask; a return wins.
// Assumes: bit 0 is the constant-zero register and is forced to in-use.
module pfl_state #(
    parameter int NBITS = pfl_pkg::PFL_DEF_NPREG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] claim_i,
    input  logic [NBITS-1:0] ret_i,
    output logic [NBITS-1:0] free_o
);
    localparam logic [NBITS-1:0] RST_FREE = {{(NBITS-1){1'b1}}, 1'b0};

    logic [NBITS-1:0] free_q;
    logic [NBITS-1:0] free_d;

    // next pool: drop claimed registers, add returned ones, keep 0 reserved
    always_comb begin
        free_d    = (free_q & ~claim_i) | ret_i;
        free_d[0] = 1'b0;
    end

    // pool register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= RST_FREE;
        else        free_q <= free_d;
    end

    assign free_o = free_q;
endmodule

// File: rtl/pfl_freelist.sv
// Module: pfl_freelist (top)
// Offers SLOTS distinct free physical registers at once. Port k takes the
// (k+1)-th lowest free index. An alloc on a valid port claims the register
// from the next clock on; a release returns one register from the next clock.
// Assumes: register 0 is never allocatable. An alloc on an invalid port and a
// release of index 0 or of an index >= NUM_PREGS are ignored.
module pfl_freelist #(
    parameter int NUM_PREGS = pfl_pkg::PFL_DEF_NPREG,
    parameter int SLOTS     = pfl_pkg::PFL_DEF_SLOTS,
    localparam int IW = $clog2(NUM_PREGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SLOTS-1:0]          alloc_i,
    output logic [SLOTS-1:0]          offer_valid_o,
    output logic [SLOTS-1:0][IW-1:0]  offer_idx_o,
    input  logic                      rel_valid_i,
    input  logic [IW-1:0]             rel_idx_i
);
    logic [NUM_PREGS-1:0]             free_vec;
    logic [SLOTS:0][NUM_PREGS-1:0]    avail;
    logic [SLOTS-1:0][NUM_PREGS-1:0]  pick_oh;
    logic [NUM_PREGS-1:0]             claim_mask;
    logic [NUM_PREGS-1:0]             ret_mask;

    pfl_state #(.NBITS(NUM_PREGS)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .claim_i (claim_mask),
        .ret_i   (ret_mask),
        .free_o  (free_vec)
    );

    assign avail[0] = free_vec;

    // one picker per port, each masking out the choices of lower ports
    for (genvar k = 0; k < SLOTS; k++) begin : g_port
        pfl_pick #(.NBITS(NUM_PREGS)) u_pick (
            .cand_i     (avail[k]),
            .pick_oh_o  (pick_oh[k]),
            .pick_idx_o (offer_idx_o[k]),
            .pick_vld_o (offer_valid_o[k])
        );
        assign avail[k+1] = avail[k] & ~pick_oh[k];
    end

    // claim mask: one-hot choices of ports whose alloc strobe is high
    always_comb begin
        claim_mask = '0;
        for (int k = 0; k < SLOTS; k++) begin
            if (alloc_i[k]) claim_mask = claim_mask | pick_oh[k];
        end
    end

    // return mask: decode the release index, excluding the zero register
    always_comb begin
        ret_mask = '0;
        for (int i = 1; i < NUM_PREGS; i++) begin
            ret_mask[i] = rel_valid_i && (rel_idx_i == IW'(i));
        end
    end
endmodule

// File: rtl/pfl_freelist_chk.sv
// Module: pfl_freelist_chk
// Property checker bound to pfl_freelist. It observes only the ports.
// Assumes: synchronous active-low reset; checks are off while in reset.
module pfl_freelist_chk #(
    parameter int NUM_PREGS = pfl_pkg::PFL_DEF_NPREG,
    parameter int SLOTS     = pfl_pkg::PFL_DEF_SLOTS,
    localparam int IW = $clog2(NUM_PREGS)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [SLOTS-1:0]          alloc_i,
    input logic [SLOTS-1:0]          offer_valid_o,
    input logic [SLOTS-1:0][IW-1:0]  offer_idx_o,
    input logic                      rel_valid_i,
    input logic [IW-1:0]             rel_idx_i
);
    // true when index r is presented by some valid port
    function automatic logic shown(input logic [SLOTS-1:0] v,
                                   input logic [SLOTS-1:0][IW-1:0] ix,
                                   input logic [IW-1:0] r);
        logic hit;
        hit = 1'b0;
        for (int k = 0; k < SLOTS; k++) if (v[k] && ix[k] == r) hit = 1'b1;
        return hit;
    endfunction

    logic eff_alloc;
    logic eff_rel;
    assign eff_alloc = |(alloc_i & offer_valid_o);
    assign eff_rel   = rel_valid_i && (rel_idx_i != '0);

    for (genvar k = 0; k < SLOTS; k++) begin : g_k
        a_r10_no_zero: assert property (@(posedge clk) disable iff (!rst_n)
            offer_valid_o[k] |-> offer_idx_o[k] != '0);
        a_r4_idle_idx: assert property (@(posedge clk) disable iff (!rst_n)
            !offer_valid_o[k] |-> offer_idx_o[k] == '0);
        a_r5_taken: assert property (@(posedge clk) disable iff (!rst_n)
            (alloc_i[k] && offer_valid_o[k] &&
             !(rel_valid_i && rel_idx_i == offer_idx_o[k]))
            |=> !shown(offer_valid_o, offer_idx_o, $past(offer_idx_o[k])));
        if (k + 1 < SLOTS) begin : g_pref
            a_r4_prefix: assert property (@(posedge clk) disable iff (!rst_n)
                offer_valid_o[k+1] |-> offer_valid_o[k]);
            a_r2_ascend: assert property (@(posedge clk) disable iff (!rst_n)
                offer_valid_o[k+1] |-> offer_idx_o[k+1] > offer_idx_o[k]);
        end
        for (genvar j = k + 1; j < SLOTS; j++) begin : g_j
            a_r3_distinct: assert property (@(posedge clk) disable iff (!rst_n)
                (offer_valid_o[k] && offer_valid_o[j])
                |-> offer_idx_o[k] != offer_idx_o[j]);
        end
    end

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!eff_alloc && !eff_rel) |=> ($stable(offer_valid_o) && $stable(offer_idx_o)));
    a_r8_zero_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!eff_alloc && rel_valid_i && rel_idx_i == '0)
        |=> ($stable(offer_valid_o) && $stable(offer_idx_o)));
endmodule

bind pfl_freelist pfl_freelist_chk #(.NUM_PREGS(NUM_PREGS), .SLOTS(SLOTS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_i       (alloc_i),
    .offer_valid_o (offer_valid_o),
    .offer_idx_o   (offer_idx_o),
    .rel_valid_i   (rel_valid_i),
    .rel_idx_i     (rel_idx_i)
);

// File: tb/pfl_freelist_test.sv
// Scoreboard bench for pfl_freelist. A driver task queues the offers expected
// in each cycle from a model of the pool; a monitor compares at falling edges.
module pfl_freelist_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 64;
    localparam int NS = 4;
    localparam int IW = 6;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NS-1:0]         alloc_i = '0;
    logic [NS-1:0]         offer_valid_o;
    logic [NS-1:0][IW-1:0] offer_idx_o;
    logic                  rel_valid_i = 1'b0;
    logic [IW-1:0]         rel_idx_i = '0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [NP-1:0]           m_free;
    logic [NS-1:0]           q_v[$];
    logic [NS*IW-1:0]        q_ix[$];
    string                   q_tag[$];

    pfl_freelist #(.NUM_PREGS(NP), .SLOTS(NS)) uut (
        .clk(clk), .rst_n(rst_n), .alloc_i(alloc_i),
        .offer_valid_o(offer_valid_o), .offer_idx_o(offer_idx_o),
        .rel_valid_i(rel_valid_i), .rel_idx_i(rel_idx_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // expected offers: the NS lowest set bits of the model pool
    task automatic expect_offers(output logic [NS-1:0] v, output logic [NS*IW-1:0] ix);
        int n;
        n = 0; v = '0; ix = '0;
        for (int i = 0; i < NP; i++) begin
            if (m_free[i] && n < NS) begin
                v[n] = 1'b1;
                ix[n*IW +: IW] = IW'(i);
                n++;
            end
        end
    endtask

    // driver: apply inputs, queue this cycle's expectation, update model at edge
    task automatic step(input logic [NS-1:0] al, input logic rv,
                        input logic [IW-1:0] ri, input string tag);
        logic [NS-1:0] v;
        logic [NS*IW-1:0] ix;
        expect_offers(v, ix);
        alloc_i = al; rel_valid_i = rv; rel_idx_i = ri;
        q_v.push_back(v); q_ix.push_back(ix); q_tag.push_back(tag);
        @(posedge clk);
        for (int k = 0; k < NS; k++) if (al[k] && v[k]) m_free[ix[k*IW +: IW]] = 1'b0;
        if (rv && ri != '0) m_free[ri] = 1'b1;
        #1;
    endtask

    // monitor: pop expectation and compare at each falling edge
    always @(negedge clk) begin
        if (q_v.size() > 0) begin
            logic [NS-1:0] ev;
            logic [NS*IW-1:0] eix;
            string tg;
            logic dup, zro;
            ev = q_v.pop_front(); eix = q_ix.pop_front(); tg = q_tag.pop_front();
            for (int k = 0; k < NS; k++) begin
                checks++;
                if (offer_valid_o[k] !== ev[k] || offer_idx_o[k] !== eix[k*IW +: IW]) begin
                    errors++;
                    $display("FAIL %s port %0d: got v=%0b idx=%0d, expected v=%0b idx=%0d",
                             tg, k, offer_valid_o[k], offer_idx_o[k], ev[k], eix[k*IW +: IW]);
                end
            end
            dup = 1'b0; zro = 1'b0;
            for (int a = 0; a < NS; a++) begin
                if (offer_valid_o[a] && offer_idx_o[a] == '0) zro = 1'b1;
                for (int b = a + 1; b < NS; b++)
                    if (offer_valid_o[a] && offer_valid_o[b] && offer_idx_o[a] == offer_idx_o[b]) dup = 1'b1;
            end
            checks++;
            if (dup) begin errors++; $display("FAIL R3: got duplicate offer, expected distinct"); end
            checks++;
            if (zro) begin errors++; $display("FAIL R10: got index 0 offered, expected nonzero"); end
        end
    end

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        m_free = {{(NP-1){1'b1}}, 1'b0};
        repeat (2) @(posedge clk);
        #1;
        // R1: state after synchronous reset, offers 1..NS
        q_v.push_back('1);
        q_ix.push_back({6'd4, 6'd3, 6'd2, 6'd1});
        q_tag.push_back("R1");
        @(negedge clk); #1;
        @(posedge clk); #1;
        rst_n = 1'b1;
        step(4'b0000, 1'b0, '0, "R6");              // idle: offers hold
        step(4'b0000, 1'b0, '0, "R6");
        step(4'b0001, 1'b0, '0, "R5");              // claim reg 1
        step(4'b0100, 1'b0, '0, "R5");              // now 2,3,4,5 -> claim 4
        step(4'b0000, 1'b0, '0, "R2");              // offers 2,3,5,6 skip hole
        step(4'b1010, 1'b0, '0, "R2");              // claim 3 and 6
        step(4'b0000, 1'b0, '0, "R2");
        step(4'b0000, 1'b1, 6'd4, "R7");            // return 4
        step(4'b0000, 1'b0, '0, "R7");              // 2,4,5,7
        for (int n = 0; n < 20; n++) step(4'b1111, 1'b0, '0, "R4");  // drain pool
        step(4'b1111, 1'b0, '0, "R9");              // alloc with nothing valid
        step(4'b0000, 1'b1, 6'd0, "R8");            // release of zero ignored
        step(4'b0000, 1'b0, '0, "R8");
        step(4'b0000, 1'b1, 6'd40, "R7");
        step(4'b0000, 1'b1, 6'd10, "R7");
        step(4'b1100, 1'b1, 6'd63, "R9");           // ports 2,3 invalid
        step(4'b0000, 1'b0, '0, "R4");              // 10,40,63 valid, port3 low
        step(4'b0010, 1'b0, '0, "R5");              // claim 40
        step(4'b0000, 1'b0, '0, "R2");
        step(4'b0000, 1'b0, '0, "R6");
        @(negedge clk); #1;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule